// File: doc/BRIEF.md
# Clocked Host Port for a 2K x 8 Asynchronous Static RAM

This block lets logic running on one clock read and write an asynchronous static RAM of 2048 bytes. The host offers one request at a time: an address, a byte to write and a read/write flag, qualified by a valid signal and accepted while the controller shows ready. The controller then runs the RAM's strobes (active-low chip enable, output enable and write enable) through a fixed sequence of phases. A read returns its byte on a one-clock valid pulse.

The length of each phase is counted in clock cycles. Each count is derived at elaboration from the clock period and the RAM's minimum timings in nanoseconds, rounded up, with a floor of one cycle. Writes are terminated by write enable, with separate address-setup, pulse and hold/recovery phases. After every read the controller waits a bus-release interval before it may drive the data pins again. The data pins are presented as a split output, output-enable and input, which the pad ring combines into one bidirectional bus.

Top module: `sram_host_port`

## Requirements
- R1: While reset is low, and on the first cycle after it, chip enable, output enable and write enable are high, the data driver is off, ready is high and the read-valid output is low. This holds even if reset arrives in the middle of an access.
- R2: While the controller is idle (ready high), all three strobes are high and the data driver is off.
- R3: A write first drives the address with chip enable low and write enable high for ceil(tAS/Tclk) cycles, with a minimum of 1. Write enable is then low for max(ceil(60 ns/Tclk), ceil(30 ns/Tclk)) cycles, which is 6 at 10 ns. The address does not change while write enable is low.
- R4: The write data is driven and stable for the whole write-enable-low window. After write enable rises, data and address stay driven for a hold phase of max(ceil(10 ns/Tclk), write-cycle fill) cycles. The whole write occupies at least ceil(100 ns/Tclk) cycles, which is 10 at 10 ns.
- R5: A read holds chip enable and output enable low with write enable high and a stable address for max(ceil(100 ns/Tclk), ceil(40 ns/Tclk)) cycles, which is 10 at 10 ns. The data pins are sampled on the last of those cycles. Read-valid is high for exactly one clock, in the cycle after that sample.
- R6: The byte returned by a read equals the byte most recently written to that address.
- R7: After a read, the data driver stays off for max(ceil(40 ns/Tclk), ceil(40 ns/Tclk)) cycles, which is 4 at 10 ns, counted from the clock edge at which output enable and chip enable rise.
- R8: A request is accepted only on a clock edge where valid and ready are both high. Ready stays low from acceptance until the last phase ends: 10 cycles for a write and 14 for a read at 10 ns. Request inputs that change during that time have no effect on the address or data presented to the RAM.
- R9: Output enable is high whenever write enable is low and whenever the data driver is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| req_ready | output | 1 | Controller can accept a request |
| rd_valid | output | 1 | One-clock pulse: rd_data holds read result |
| rd_data | output | DATA_W | Read result |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DATA_W | Data to drive onto the RAM data pins |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Value seen on the RAM data pins |

## Verification
Taking the accepting edge as edge 0 at 10 ns, a write returns ready after edge 10, and a read raises rd_valid after edge 10 and returns ready after edge 14. The bench samples on falling clock edges and counts cycles from the accepting edge, so each of these results is compared in exactly the cycle it is due. A clocked RAM model checks each strobe phase against its minimum length at the edge that ends it. The model also returns valid data only from the tenth access cycle onward, and it counts bus-release cycles to detect a driver that is enabled too early.

// File: rtl/sram_host_port_pkg.sv
// Shared types and elaboration-time helpers for the SRAM host port.
// Assumes all timing figures are non-negative nanosecond integers.
package sram_host_port_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WR_SETUP,
        PH_WR_PULSE,
        PH_WR_HOLD,
        PH_RD_ACCESS,
        PH_RD_RELEASE
    } phase_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    // Round a nanosecond figure up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels presented during each phase.
    function automatic strobe_t strobe_of(input phase_t ph);
        strobe_t s;
        case (ph)
            PH_WR_SETUP:  s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
            PH_WR_PULSE:  s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
            PH_WR_HOLD:   s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
            PH_RD_ACCESS: s = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
            default:      s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that measures the length of one strobe phase.
// A load sets it to (phase length - 1); "expired" is high in the phase's
// last cycle. Assumes the sequencer loads it on every phase entry.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/sram_strobe_seq.sv
// Phase sequencer: accepts one host request, steps through the write or
// read phases, registers the strobes and captures read data.
// Assumes phase lengths of at least one cycle, supplied by the top.
module sram_strobe_seq
    import sram_host_port_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    parameter int WS_CYC = 1,
    parameter int WP_CYC = 6,
    parameter int WH_CYC = 3,
    parameter int RA_CYC = 10,
    parameter int RR_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic              tmr_expired
);

    phase_t  ph, ph_nxt;
    strobe_t strb;

    // Choose the next phase and the timer value for it.
    always_comb begin
        ph_nxt   = ph;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (ph)
            PH_IDLE: if (req_valid) begin
                ph_nxt   = req_write ? PH_WR_SETUP : PH_RD_ACCESS;
                tmr_load = 1'b1;
                tmr_val  = req_write ? CNT_W'(WS_CYC - 1) : CNT_W'(RA_CYC - 1);
            end
            PH_WR_SETUP: if (tmr_expired) begin
                ph_nxt   = PH_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_CYC - 1);
            end
            PH_WR_PULSE: if (tmr_expired) begin
                ph_nxt   = PH_WR_HOLD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WH_CYC - 1);
            end
            PH_RD_ACCESS: if (tmr_expired) begin
                ph_nxt   = PH_RD_RELEASE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RR_CYC - 1);
            end
            PH_WR_HOLD, PH_RD_RELEASE: if (tmr_expired) ph_nxt = PH_IDLE;
            default: ph_nxt = PH_IDLE;
        endcase
    end

    // Advance the phase and register the strobes decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= PH_IDLE;
            strb <= strobe_of(PH_IDLE);
        end else begin
            ph   <= ph_nxt;
            strb <= strobe_of(ph_nxt);
        end
    end

    // Latch the request fields on acceptance; they stay fixed until idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (ph == PH_IDLE && req_valid) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Sample the data pins in the last access cycle and pulse read-valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (ph == PH_RD_ACCESS) && tmr_expired;
            if (ph == PH_RD_ACCESS && tmr_expired) rd_data <= mem_dq_in;
        end
    end

    assign req_ready = (ph == PH_IDLE);
    assign mem_ce_n  = strb.ce_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_we_n  = strb.we_n;
    assign mem_dq_oe = strb.drive;

    // Length of the current write-enable-low run, saturating; used by a check.
    logic [CNT_W:0] we_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                         we_low_run <= '0;
        else if (mem_we_n)                  we_low_run <= '0;
        else if (we_low_run != '1)          we_low_run <= we_low_run + 1'b1;
    end

    assert_we_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_run >= (CNT_W+1)'(WP_CYC)));

    assert_we_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_we_n)));

    assert_addr_stable_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

    assert_no_read_while_driving_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

    assert_idle_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    assert_rd_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_data_held_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

endmodule

// File: rtl/sram_host_port.sv
// Top of the SRAM host port: turns nanosecond timing parameters into phase
// cycle counts and connects the sequencer to its phase timer.
// Assumes CLK_PERIOD_NS is the true period of clk.
module sram_host_port
    import sram_host_port_pkg::*;
#(
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_AS_NS       = 0,
    parameter int T_WP_NS       = 60,
    parameter int T_DW_NS       = 30,
    parameter int T_DH_NS       = 10,
    parameter int T_WR_NS       = 10,
    parameter int T_WC_NS       = 100,
    parameter int T_RC_NS       = 100,
    parameter int T_AA_NS       = 100,
    parameter int T_OE_NS       = 40,
    parameter int T_OHZ_NS      = 40,
    parameter int T_CHZ_NS      = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int WS_CYC  = ns_to_cycles(T_AS_NS, CLK_PERIOD_NS);
    localparam int WP_CYC  = imax(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_DW_NS, CLK_PERIOD_NS));
    localparam int WC_CYC  = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int WH_MIN  = imax(ns_to_cycles(T_DH_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_WR_NS, CLK_PERIOD_NS));
    localparam int WH_CYC  = imax(WH_MIN, WC_CYC - WS_CYC - WP_CYC);
    localparam int RA_CYC  = imax(imax(ns_to_cycles(T_RC_NS, CLK_PERIOD_NS),
                                       ns_to_cycles(T_AA_NS, CLK_PERIOD_NS)),
                                  ns_to_cycles(T_OE_NS, CLK_PERIOD_NS));
    localparam int RR_CYC  = imax(ns_to_cycles(T_OHZ_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_CHZ_NS, CLK_PERIOD_NS));
    localparam int MAX_CYC = imax(imax(imax(WS_CYC, WP_CYC), imax(WH_CYC, RA_CYC)), RR_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_strobe_seq #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CNT_W (CNT_W),
        .WS_CYC (WS_CYC), .WP_CYC (WP_CYC), .WH_CYC (WH_CYC),
        .RA_CYC (RA_CYC), .RR_CYC (RR_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .mem_addr    (mem_addr),
        .mem_ce_n    (mem_ce_n),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_oe   (mem_dq_oe),
        .mem_dq_in   (mem_dq_in),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .tmr_expired (tmr_expired)
    );

endmodule

// File: tb/sram_host_port_bench.sv
// Bench: clocked 2K x 8 RAM model with strobe checks, a vector table of
// host operations, then directed reset and corner cases.
module sram_host_port_bench;

    localparam int WP_MIN   = 60 / 10;
    localparam int RA_LEN   = 100 / 10;
    localparam int REL_LEN  = 40 / 10;
    localparam int WR_BUSY  = 100 / 10;
    localparam int RD_BUSY  = RA_LEN + REL_LEN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [10:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    always #5 clk = ~clk;

    sram_host_port u_sram_host_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int tests = 0, fails = 0, m_tests = 0, m_fails = 0;
    logic [7:0] shadow [2048];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- RAM model ----------------
    logic [7:0]  ram [2048];
    logic        p_we_n = 1'b1, p_ce_n = 1'b1;
    logic [10:0] p_addr = '0, w_addr = '0;
    logic [7:0]  p_dout = '0, w_data = '0;
    int          pw = 0, acc = 0, rel = 0;
    wire         ram_drv = !mem_ce_n && !mem_oe_n && mem_we_n;

    assign mem_dq_in = (ram_drv && acc >= RA_LEN - 1) ? ram[mem_addr] : 8'hEE;

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        m_tests++;
        if (!ok) begin
            m_fails++;
            $display("FAIL %s (RAM model): actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Observe the cycle that just ended and check write/read/bus rules.
    always @(posedge clk) begin
        if (!rst_n) begin
            pw = 0; acc = 0; rel = 0;
        end else begin
            if (!mem_we_n) begin
                mchk(!mem_ce_n && mem_oe_n, "R9 strobes in write", {mem_ce_n, mem_oe_n}, 1);
                mchk(mem_dq_oe, "R4 data driven in pulse", mem_dq_oe, 1);
                if (pw == 0)
                    mchk(p_we_n && !p_ce_n && p_addr == mem_addr, "R3 address setup", p_we_n, 1);
                else
                    mchk(mem_addr == p_addr && mem_dq_out == p_dout, "R3 address/data stable", mem_addr, p_addr);
                pw++; w_addr = mem_addr; w_data = mem_dq_out;
            end else if (pw != 0) begin
                mchk(pw >= WP_MIN, "R3 write pulse width", pw, WP_MIN);
                mchk(mem_dq_oe && mem_dq_out == w_data && mem_addr == w_addr,
                     "R4 data hold", mem_dq_out, w_data);
                ram[w_addr] = w_data;
                pw = 0;
            end
            if (mem_dq_oe) mchk(!ram_drv && rel == 0, "R7 bus turnaround", rel, 0);
            if (ram_drv) begin
                mchk(acc == 0 || mem_addr == p_addr, "R5 read address stable", mem_addr, p_addr);
                acc++; rel = REL_LEN;
            end else begin
                acc = 0;
                if (rel > 0) rel--;
            end
            p_we_n = mem_we_n; p_ce_n = mem_ce_n; p_addr = mem_addr; p_dout = mem_dq_out;
        end
    end

    // ---------------- stimulus ----------------
    // {write, addr[10:0], data[7:0]}
    localparam logic [19:0] VEC [12] = '{
        {1'b1, 11'h000, 8'h5A}, {1'b1, 11'h7FF, 8'hA5}, {1'b1, 11'h123, 8'hFF},
        {1'b0, 11'h000, 8'h00}, {1'b0, 11'h7FF, 8'h00}, {1'b0, 11'h123, 8'h00},
        {1'b1, 11'h123, 8'h00}, {1'b0, 11'h123, 8'h00}, {1'b0, 11'h456, 8'h00},
        {1'b1, 11'h400, 8'h3C}, {1'b1, 11'h401, 8'hC3}, {1'b0, 11'h400, 8'h00}
    };

    task automatic do_op(input logic wr, input logic [10:0] a, input logic [7:0] d);
        int n, rd_at, pulses;
        logic [7:0] got;
        bit addr_ok;
        @(negedge clk);
        chk(req_ready, "R8 ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;   // must not reach the RAM
        n = 0; rd_at = -1; pulses = 0; got = '0; addr_ok = 1'b1;
        while (!req_ready && n < 100) begin
            if (rd_valid) begin pulses++; rd_at = n; got = rd_data; end
            if (!mem_ce_n && mem_addr != a) addr_ok = 1'b0;
            @(negedge clk); n++;
        end
        chk(addr_ok, "R8 latched address ignores later inputs", mem_addr, a);
        if (wr) begin
            chk(n == WR_BUSY, "R4/R8 write busy cycles", n, WR_BUSY);
            shadow[a] = d;
        end else begin
            chk(n == RD_BUSY, "R8/R7 read busy cycles", n, RD_BUSY);
            chk(rd_at == RA_LEN, "R5 read-valid cycle", rd_at, RA_LEN);
            chk(pulses == 1, "R5 read-valid single pulse", pulses, 1);
            chk(got == shadow[a], "R6 read data", got, shadow[a]);
        end
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R2 idle strobes",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests + m_tests, fails + m_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin ram[i] = 8'h00; shadow[i] = 8'h00; end
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rd_valid,
            "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 first cycle after reset", req_ready, 1);

        for (int k = 0; k < 12; k++) do_op(VEC[k][19], VEC[k][18:8], VEC[k][7:0]);

        // Back-to-back write then read of the same boundary address.
        do_op(1'b1, 11'h7FF, 8'h01);
        do_op(1'b0, 11'h7FF, 8'h00);

        // Valid low while idle: nothing starts (R8, R2).
        repeat (5) @(negedge clk);
        chk(req_ready && mem_ce_n, "R8 no request no access", mem_ce_n, 1);

        // Reset in the middle of a read returns the strobes high (R1).
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h010;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!mem_ce_n && !mem_oe_n, "R5 read under way", mem_oe_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rd_valid,
            "R1 reset mid-access", {mem_ce_n, mem_oe_n}, 2'b11);
        rst_n = 1'b1;
        repeat (REL_LEN) @(negedge clk);
        do_op(1'b0, 11'h400, 8'h00);
        finish_run();
    end

endmodule